// File: doc/BRIEF.md
# Read-Signature Command Detector

This block sits beside a static RAM core and listens to its access traffic. Each access reaches it as a one-clock strobe, already synchronized to the local clock. With the strobe come the access address and a write flag. The block looks for a fixed run of six consecutive read addresses. The first five addresses form a common prefix, and the sixth selects the command. When the whole run is seen, the block raises a one-cycle request toward the controller that copies the array to nonvolatile storage (store) or back from it (recall).

Commands are carried by ordinary read cycles, so the memory stays pin-compatible with a plain SRAM. Any access that does not fit the run drops the match without notice:
- a write,
- a wrong address,
- a repeat of the previous address.

A busy input from the nonvolatile controller freezes detection at idle while a transfer runs.

Top module: `seqcmd_detect`

## Requirements
- R1: Reset, active low and asynchronous, forces `match_step` to 0 and `store_req` and `recall_req` low. Reset in the middle of a run discards it.
- R2: Reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `store_req` for one cycle. The pulse appears in the cycle after the clock edge that takes the sixth strobe, and `match_step` returns to 0.
- R3: The same five-address prefix followed by a read at 0x0C63 raises `recall_req` for one cycle, with the same timing as R2, and `match_step` returns to 0.
- R4: A sixth read at 0x339C is reserved. It raises neither request and returns `match_step` to 0.
- R5: A strobe with `acc_write` high returns `match_step` to 0 at any step and raises no request.
- R6: A read at an address that is not the next expected one returns `match_step` to 0. This includes a second read of the address just matched.
- R7: An unexpected read at 0x0E38 sets `match_step` to 1 and does not return it to idle.
- R8: While `busy` is high, strobes are ignored, `match_step` is forced to 0 and no request is raised.
- R9: Only address bits 13:0 are compared, and any higher address bits are ignored.
- R10: `store_req` and `recall_req` are never high together, and neither is high for two cycles in a row.
- R11: In cycles without a strobe (and with `busy` low), `match_step` holds its value, so gaps between accesses do not break a run.
- R12: `match_step` gives the number of prefix reads matched so far, 0 to 5. It rises by exactly one on each expected read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe marking one chip-enable access |
| acc_addr | input | ADDR_W (15) | Address of the access |
| acc_write | input | 1 | High when the access is a write |
| busy | input | 1 | Nonvolatile transfer in progress |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |
| match_step | output | 3 | Signature reads matched so far (0 to 5) |

## Verification
The bench aims at the places where a sloppy matcher goes wrong:
- A repeated read of the address just matched must abort the run. A matcher that only tracks "still on this address" would accept it and move on.
- A stray 0x0E38 in the middle of a run must restart at step 1. A design that drops to idle would miss a run that begins straight after the stray read.
- The reserved sixth code must raise no request. A design that decodes only one bit of the sixth address would let it through as a command.
- The upper address bit is set on some strobes. A full-width compare would then fail to fire.
- Strobe gaps, `busy` and writes are mixed into runs. This exposes any design that advances on idle cycles or keeps state through a transfer.

// File: rtl/seqcmd_pkg.sv
`timescale 1ns/1ps
package seqcmd_pkg;
   localparam int SIG_W      = 14;
   localparam int NUM_PREFIX = 5;
   localparam int STEP_W     = 3;
   localparam int STEP_SPAN  = 1 << STEP_W;

   localparam logic [SIG_W-1:0] CODE_STORE  = 14'h0FC0;
   localparam logic [SIG_W-1:0] CODE_RECALL = 14'h0C63;
   localparam logic [SIG_W-1:0] CODE_TEST   = 14'h339C;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_STORE  = 2'd1,
      CMD_RECALL = 2'd2,
      CMD_TEST   = 2'd3
   } seq_cmd_e;

   function automatic logic [SIG_W-1:0] prefix_code(input int idx);
      case (idx)
         0:       return 14'h0E38;
         1:       return 14'h31C7;
         2:       return 14'h03E0;
         3:       return 14'h3C1F;
         default: return 14'h303F;
      endcase
   endfunction
endpackage

// File: rtl/seqcmd_match.sv
`timescale 1ns/1ps
module seqcmd_match
   import seqcmd_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic [ADDR_W-1:0]     addr,
   output logic [NUM_PREFIX-1:0] prefix_hit,
   output seq_cmd_e              last_cmd
);
   logic [SIG_W-1:0] low_addr;
   assign low_addr = addr[SIG_W-1:0];

   for (genvar g = 0; g < NUM_PREFIX; g++) begin : g_prefix
      assign prefix_hit[g] = (low_addr == prefix_code(g));
   end

   always_comb begin
      if (low_addr == CODE_STORE)       last_cmd = CMD_STORE;
      else if (low_addr == CODE_RECALL) last_cmd = CMD_RECALL;
      else if (low_addr == CODE_TEST)   last_cmd = CMD_TEST;
      else                              last_cmd = CMD_NONE;
   end

   always_comb begin
      a_r10_hit_onehot: assert ($onehot0(prefix_hit));
   end
endmodule

// File: rtl/seqcmd_tracker.sv
`timescale 1ns/1ps
module seqcmd_tracker
   import seqcmd_pkg::*;
#(
   parameter bit STEP_ONEHOT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic                  busy,
   input  logic [NUM_PREFIX-1:0] prefix_hit,
   input  seq_cmd_e              last_cmd,
   output logic [STEP_W-1:0]     step,
   output logic                  fire_store,
   output logic                  fire_recall
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_PREFIX);

   logic [STEP_SPAN-1:0] expect_vec;
   logic                 expect_hit;
   logic                 at_final;
   logic                 take_read;
   logic [STEP_W-1:0]    step_nxt;

   assign expect_vec = {{(STEP_SPAN-NUM_PREFIX){1'b0}}, prefix_hit};
   assign expect_hit = expect_vec[step];
   assign at_final   = (step == LAST_STEP);
   assign take_read  = acc_valid && !busy && !acc_write;

   always_comb begin
      if (busy)                  step_nxt = '0;
      else if (!acc_valid)       step_nxt = step;
      else if (acc_write)        step_nxt = '0;
      else if (expect_hit)       step_nxt = step + STEP_W'(1);
      else if (prefix_hit[0])    step_nxt = STEP_W'(1);
      else                       step_nxt = '0;
   end

   assign fire_store  = take_read && at_final && (last_cmd == CMD_STORE);
   assign fire_recall = take_read && at_final && (last_cmd == CMD_RECALL);

   if (STEP_ONEHOT) begin : g_onehot
      logic [NUM_PREFIX:0] oh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oh_q <= (NUM_PREFIX+1)'(1);
         else        oh_q <= (NUM_PREFIX+1)'(1) << step_nxt;
      end
      always_comb begin
         step = '0;
         for (int i = 0; i <= NUM_PREFIX; i++)
            if (oh_q[i]) step = STEP_W'(i);
      end
   end else begin : g_binary
      logic [STEP_W-1:0] bin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bin_q <= '0;
         else        bin_q <= step_nxt;
      end
      assign step = bin_q;
   end

   a_r12_step_range: assert property (@(posedge clk) disable iff (!rst_n)
      step <= LAST_STEP);
   a_r5_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> (step == '0));
   a_r8_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (step == '0));
   a_r11_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !busy) |=> $stable(step));
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (take_read && prefix_hit[0]) |=> (step == STEP_W'(1)));
endmodule

// File: rtl/seqcmd_pulse.sv
`timescale 1ns/1ps
module seqcmd_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_store,
   input  logic fire_recall,
   output logic store_req,
   output logic recall_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_req  <= 1'b0;
         recall_req <= 1'b0;
      end else begin
         store_req  <= fire_store;
         recall_req <= fire_recall && !fire_store;
      end
   end

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_req && recall_req));
   a_r10_store_single: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);
   a_r10_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> !recall_req);
endmodule

// File: rtl/seqcmd_detect.sv
`timescale 1ns/1ps
module seqcmd_detect
   import seqcmd_pkg::*;
#(
   parameter int ADDR_W      = 15,
   parameter bit STEP_ONEHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              busy,
   output logic              store_req,
   output logic              recall_req,
   output logic [2:0]        match_step
);
   if (ADDR_W < SIG_W) begin : g_bad_width
      $error("seqcmd_detect: ADDR_W must cover the compared address bits");
   end

   logic [NUM_PREFIX-1:0] prefix_hit;
   seq_cmd_e              last_cmd;
   logic [STEP_W-1:0]     step;
   logic                  fire_store;
   logic                  fire_recall;

   seqcmd_match #(.ADDR_W(ADDR_W)) u_match (
      .addr       (acc_addr),
      .prefix_hit (prefix_hit),
      .last_cmd   (last_cmd)
   );

   seqcmd_tracker #(.STEP_ONEHOT(STEP_ONEHOT)) u_tracker (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .acc_write   (acc_write),
      .busy        (busy),
      .prefix_hit  (prefix_hit),
      .last_cmd    (last_cmd),
      .step        (step),
      .fire_store  (fire_store),
      .fire_recall (fire_recall)
   );

   seqcmd_pulse u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_store  (fire_store),
      .fire_recall (fire_recall),
      .store_req   (store_req),
      .recall_req  (recall_req)
   );

   assign match_step = step;

   a_r2_store_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> ($past(match_step) == 3'd5 && match_step == 3'd0));
   a_r3_recall_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |-> ($past(match_step) == 3'd5 && match_step == 3'd0));
   a_r8_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!store_req && !recall_req));
endmodule

// File: tb/seqcmd_detect_bench.sv
`timescale 1ns/1ps
module seqcmd_detect_bench;
   localparam int AW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;
   logic          busy = 1'b0;
   logic          store_req, recall_req;
   logic [2:0]    match_step;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   seqcmd_detect #(.ADDR_W(AW)) u_seqcmd_detect (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_write(acc_write), .busy(busy), .store_req(store_req),
      .recall_req(recall_req), .match_step(match_step)
   );

   // vector: [25:22] req, [21] busy, [20] write, [19:5] addr, [4:2] step, [1] store, [0] recall
   function automatic logic [25:0] v(input int rq, input bit b, input bit w,
                                     input logic [14:0] a, input int s,
                                     input bit st, input bit rc);
      return {4'(rq), b, w, a, 3'(s), st, rc};
   endfunction

   localparam int NV = 41;
   localparam logic [25:0] VEC [NV] = '{
      v(12,0,0,15'h0E38,1,0,0), v(12,0,0,15'h31C7,2,0,0), v(12,0,0,15'h03E0,3,0,0),
      v(12,0,0,15'h3C1F,4,0,0), v(12,0,0,15'h303F,5,0,0),
      v(2,0,0,15'h0FC0,0,1,0),                                  // R2 store
      v(3,0,0,15'h0E38,1,0,0), v(3,0,0,15'h31C7,2,0,0), v(3,0,0,15'h03E0,3,0,0),
      v(3,0,0,15'h3C1F,4,0,0), v(3,0,0,15'h303F,5,0,0),
      v(3,0,0,15'h0C63,0,0,1),                                  // R3 recall
      v(4,0,0,15'h0E38,1,0,0), v(4,0,0,15'h31C7,2,0,0), v(4,0,0,15'h03E0,3,0,0),
      v(4,0,0,15'h3C1F,4,0,0), v(4,0,0,15'h303F,5,0,0),
      v(4,0,0,15'h339C,0,0,0),                                  // R4 reserved code
      v(6,0,0,15'h0E38,1,0,0), v(6,0,0,15'h31C7,2,0,0),
      v(6,0,0,15'h31C7,0,0,0),                                  // R6 duplicate
      v(5,0,0,15'h0E38,1,0,0), v(5,0,0,15'h31C7,2,0,0),
      v(5,0,1,15'h03E0,0,0,0),                                  // R5 write abort
      v(7,0,0,15'h0E38,1,0,0), v(7,0,0,15'h31C7,2,0,0),
      v(7,0,0,15'h0E38,1,0,0),                                  // R7 restart at 1
      v(7,0,0,15'h31C7,2,0,0), v(7,0,0,15'h03E0,3,0,0),
      v(9,0,0,15'h7C1F,4,0,0), v(9,0,0,15'h303F,5,0,0),         // R9 upper bit set
      v(9,0,0,15'h4FC0,0,1,0),
      v(8,0,0,15'h0E38,1,0,0), v(8,1,0,15'h31C7,0,0,0),         // R8 busy
      v(8,0,0,15'h31C7,0,0,0),
      v(6,0,0,15'h0E38,1,0,0), v(6,0,0,15'h31C7,2,0,0), v(6,0,0,15'h03E0,3,0,0),
      v(6,0,0,15'h3C1F,4,0,0), v(6,0,0,15'h303F,5,0,0),
      v(6,0,0,15'h1234,0,0,0)                                   // R6 wrong sixth
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic strobe(input logic [14:0] a, input bit w, input bit b);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w; busy = b;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; busy = 1'b0;
   endtask

   task automatic outs(input string req, input int s, input bit st, input bit rc);
      check(req, "match_step", 32'(match_step), 32'(s));
      check(req, "store_req",  32'(store_req),  32'(st));
      check(req, "recall_req", 32'(recall_req), 32'(rc));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      outs("R1", 0, 0, 0);                       // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      outs("R1", 0, 0, 0);                       // R1 after release

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][25:22], i);
         strobe(VEC[i][19:5], VEC[i][20], VEC[i][21]);
         outs(tag, int'(VEC[i][4:2]), VEC[i][1], VEC[i][0]);
      end

      // R11: gaps without strobes keep the step, then the run completes
      strobe(15'h0E38, 0, 0);
      strobe(15'h31C7, 0, 0);
      repeat (3) @(negedge clk);
      outs("R11", 2, 0, 0);
      strobe(15'h03E0, 0, 0);
      strobe(15'h3C1F, 0, 0);
      strobe(15'h303F, 0, 0);
      @(negedge clk);
      outs("R11", 5, 0, 0);
      strobe(15'h0C63, 0, 0);
      outs("R3", 0, 0, 1);
      @(negedge clk);
      outs("R10", 0, 0, 0);                      // R10 pulse lasts one cycle

      // R10: back-to-back store strobe at step 0 yields one pulse only
      strobe(15'h0E38, 0, 0); strobe(15'h31C7, 0, 0); strobe(15'h03E0, 0, 0);
      strobe(15'h3C1F, 0, 0); strobe(15'h303F, 0, 0);
      strobe(15'h0FC0, 0, 0);
      outs("R2", 0, 1, 0);
      strobe(15'h0FC0, 0, 0);
      outs("R10", 0, 0, 0);

      // R1: reset in the middle of a run
      strobe(15'h0E38, 0, 0); strobe(15'h31C7, 0, 0); strobe(15'h03E0, 0, 0);
      outs("R12", 3, 0, 0);
      rst_n = 1'b0;
      #1;
      outs("R1", 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      strobe(15'h3C1F, 0, 0);
      outs("R1", 0, 0, 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule